// File: doc/BRIEF.md
# Register-Programmed Single-Lane SPI Master

This block is an SPI master that software drives through a small memory-mapped register window. Software places 32-bit words into a transmit queue, programs a command word with the bit count, the clock mode, the bit order and the chip-select setup, and sets a start bit. The shift engine then clocks out one block of 1 to 32 bits on SCK/MOSI. It samples MISO on the opposite edge and places the received bits, right-justified, into a receive queue.

Completion and queue errors are held in sticky flags that software clears by writing ones. Both queues can be emptied by self-clearing flush requests. The chip select is driven from a software level bit. That level persists across any number of blocks, so one device access can span several starts. When software control is off, the selected line is asserted only while a block is shifting. SCK runs at the system clock divided by 2*CLK_DIV.

Top module: `spi_reg_master`

## Requirements
- R1: After reset, the FIFO status word at 0x014 reads 0x0000_0005 (TX empty and RX empty). The transfer status at 0x010 reads 0. All chip-select lines are high and SCK is low.
- R2: The command register at 0x000 holds these fields: start (bit 31), master (30), clock mode {CPOL,CPHA} (29:28), select index (27:26), software CS control (21), software CS level (20), LSB-first (16), byte swap (15), RX enable (12), TX enable (11) and bit count minus one (4:0). The start bit reads back 0 once the block has begun.
- R3: A block shifts len+1 bits. In the default order the first bit is bit len of the word. Each SCK half period lasts CLK_DIV system clocks. SCK idles at CPOL. MOSI is sampled by the slave on the leading edge when CPHA=0 and on the trailing edge when CPHA=1.
- R4: With LSB-first set, bit 0 is sent first. With byte swap set, the four bytes of the TX word are reversed before shifting, and the RX word is reversed after shifting.
- R5: With software CS control on, the selected line cs_no[index] follows the level bit, low being asserted, and holds across blocks. With software CS control off, the selected line is low only during a block. Unselected lines stay high.
- R6: The ready flag (bit 30 of 0x010) is set when a block completes. Writing 1 to it clears it.
- R7: With RX enabled, each block pushes the received bits, right-justified, into the RX FIFO, which is read and popped at 0x188. With RX disabled, nothing is pushed.
- R8: FIFO status bits 3:0 are TX full, TX empty, RX full and RX empty. Each FIFO holds 4 words. Writing 0x108 pushes a TX word.
- R9: The sticky error flags are TX overflow (bit 7, a write to a full TX FIFO, with the word dropped), TX underrun (bit 6, a start with TX enabled and the TX FIFO empty, which shifts zeros), RX overflow (bit 5, a completion into a full RX FIFO, with the word dropped) and RX underrun (bit 4, a read of an empty RX FIFO, which returns 0). Bit 8 is the OR of these four. Writing ones to bits 7:4 clears them.
- R10: Writing 1 to bit 15 or bit 14 of 0x014 flushes the RX or the TX FIFO. The bit reads 1 in the cycle after the write and then clears by itself.
- R11: The register at 0x004 keeps bits 14:10 and 7:0 (all other bits read 0), and 0x024 keeps a full 32-bit value. Neither affects shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 10 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while req_i is high with we_i low |
| sck_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 4 | Chip selects, active low |

## Verification
The assertions check on every cycle that SCK holds between divider ticks and that it has returned to CPOL when a block ends. They also check that the start bit self-clears and the engine becomes busy after a start, that ready follows every completion, that an empty-queue start flags underrun, that the FIFO count stays bounded, and that at most one chip select is low. Only the bench scenarios can show the serial bit order for each clock mode, bit order and byte swap, the loopback data landing in the RX queue, the half-period length, chip-select persistence across blocks, and each sticky error and flush sequence. The bench checks these through a scoreboard of expected MOSI bits.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int AW = 10;
  localparam logic [AW-1:0] A_CMD  = 10'h000;
  localparam logic [AW-1:0] A_CMD2 = 10'h004;
  localparam logic [AW-1:0] A_XSTS = 10'h010;
  localparam logic [AW-1:0] A_FSTS = 10'h014;
  localparam logic [AW-1:0] A_BLK  = 10'h024;
  localparam logic [AW-1:0] A_TXP  = 10'h108;
  localparam logic [AW-1:0] A_RXP  = 10'h188;

  localparam int B_GO = 31, B_MODE = 28, B_SEL = 26, B_SWCS = 21, B_SWLV = 20;
  localparam int B_LSB = 16, B_BSWP = 15, B_RXEN = 12, B_TXEN = 11;
  localparam int B_RDY = 30, B_RXFL = 15, B_TXFL = 14;

  localparam logic [31:0] CMD_MASK  = 32'hFC31_981F;
  localparam logic [31:0] CMD2_MASK = 32'h0000_7CFF;

  function automatic logic [31:0] swap_bytes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign rdata_o = mem_q[rp_q];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else if (flush_i) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= nxt(wp_q);
      if (pop_ok)  rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) mem_q[wp_q] <= wdata_i;
  end

  // R8
  fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int CLK_DIV = 2,
  parameter int LW      = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [(1<<LW)-1:0] tx_i,
  input  logic [LW-1:0]     len_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              lsb_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [(1<<LW)-1:0] rx_o,
  output logic              sck_o,
  output logic              mosi_o
);
  localparam int NB  = 1 << LW;
  localparam int DCW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int EW  = LW + 1;

  logic           busy_q, done_q, sck_q, cpol_q, cpha_q, lsb_q;
  logic [DCW-1:0] div_q;
  logic [EW-1:0]  edge_q;
  logic [LW-1:0]  len_q;
  logic [NB-1:0]  txsh_q, rxsh_q;
  logic           tick, lead, last, samp, shft;
  logic [LW-1:0]  pad;

  assign tick = busy_q && (div_q == DCW'(CLK_DIV - 1));
  assign lead = ~edge_q[0];
  assign last = (edge_q == {len_q, 1'b1});
  assign samp = cpha_q ? ~lead : lead;
  assign shft = cpha_q ? (lead && edge_q != '0) : ~lead;
  assign pad  = LW'(NB - 1) - len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; done_q <= 1'b0; sck_q <= 1'b0;
      cpol_q <= 1'b0; cpha_q <= 1'b0; lsb_q <= 1'b0;
      div_q <= '0; edge_q <= '0; len_q <= '0;
      txsh_q <= '0; rxsh_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        div_q  <= '0;
        edge_q <= '0;
        len_q  <= len_i;
        cpol_q <= cpol_i;
        cpha_q <= cpha_i;
        lsb_q  <= lsb_i;
        sck_q  <= cpol_i;
        txsh_q <= lsb_i ? tx_i : (tx_i << (LW'(NB - 1) - len_i));
        rxsh_q <= '0;
      end else if (busy_q) begin
        if (tick) begin
          div_q  <= '0;
          sck_q  <= ~sck_q;
          edge_q <= edge_q + 1'b1;
          if (samp) rxsh_q <= lsb_q ? {miso_i, rxsh_q[NB-1:1]} : {rxsh_q[NB-2:0], miso_i};
          if (shft) txsh_q <= lsb_q ? (txsh_q >> 1) : (txsh_q << 1);
          if (last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end else begin
        sck_q  <= cpol_i;
        cpol_q <= cpol_i;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign sck_o  = sck_q;
  assign mosi_o = lsb_q ? txsh_q[0] : txsh_q[NB-1];
  assign rx_o   = lsb_q ? (rxsh_q >> pad) : (rxsh_q & ({NB{1'b1}} >> pad));

  // R3
  sck_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !tick |=> $stable(sck_q));
  // R3
  sck_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q && $past(busy_q) && (sck_q == cpol_q));
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_reg_pkg::*;
#(
  parameter int CLK_DIV    = 2,
  parameter int FIFO_DEPTH = 4,
  parameter int NCS        = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          sck_o,
  output logic          mosi_o,
  input  logic          miso_i,
  output logic [NCS-1:0] cs_no
);
  localparam int LW = 5;
  localparam int NB = 1 << LW;

  logic [31:0] cmd_q, cmd2_q, blk_q;
  logic        rdy_q;
  logic [3:0]  err_q;   // {tx_ovf, tx_unr, rx_ovf, rx_unr}
  logic [1:0]  flush_q; // {rx, tx}

  logic wr, rd, wr_cmd, wr_tx, rd_rx, start;
  logic tx_en, rx_en, bswp;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [NB-1:0] tx_head, rx_head, eng_tx, eng_rx;
  logic eng_busy, eng_done, tx_pop, rx_push;
  logic [3:0] err_set, err_clr;

  assign wr     = req_i && we_i;
  assign rd     = req_i && !we_i;
  assign wr_cmd = wr && addr_i == A_CMD;
  assign wr_tx  = wr && addr_i == A_TXP;
  assign rd_rx  = rd && addr_i == A_RXP;
  assign tx_en  = cmd_q[B_TXEN];
  assign rx_en  = cmd_q[B_RXEN];
  assign bswp   = cmd_q[B_BSWP];
  assign start  = cmd_q[B_GO] && !eng_busy;
  assign tx_pop = start && tx_en && !tx_empty;
  assign rx_push = eng_done && rx_en && !rx_full;
  assign eng_tx = (tx_en && !tx_empty) ? (bswp ? swap_bytes(tx_head) : tx_head) : '0;

  assign err_set = {wr_tx && tx_full, start && tx_en && tx_empty,
                    eng_done && rx_en && rx_full, rd_rx && rx_empty};
  assign err_clr = (wr && addr_i == A_FSTS) ? wdata_i[7:4] : 4'b0;

  spi_word_fifo #(.W(NB), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk_i, .rst_ni, .flush_i(flush_q[0]), .push_i(wr_tx && !tx_full),
    .wdata_i, .pop_i(tx_pop), .rdata_o(tx_head), .full_o(tx_full), .empty_o(tx_empty));

  spi_word_fifo #(.W(NB), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk_i, .rst_ni, .flush_i(flush_q[1]), .push_i(rx_push),
    .wdata_i(bswp ? swap_bytes(eng_rx) : eng_rx), .pop_i(rd_rx),
    .rdata_o(rx_head), .full_o(rx_full), .empty_o(rx_empty));

  spi_shift_engine #(.CLK_DIV(CLK_DIV), .LW(LW)) u_eng (
    .clk_i, .rst_ni, .start_i(start), .tx_i(eng_tx), .len_i(cmd_q[LW-1:0]),
    .cpol_i(cmd_q[B_MODE+1]), .cpha_i(cmd_q[B_MODE]), .lsb_i(cmd_q[B_LSB]),
    .miso_i, .busy_o(eng_busy), .done_o(eng_done), .rx_o(eng_rx),
    .sck_o, .mosi_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0; cmd2_q <= '0; blk_q <= '0;
      rdy_q <= 1'b0; err_q <= '0; flush_q <= '0;
    end else begin
      if (wr_cmd)     cmd_q <= wdata_i & CMD_MASK;
      else if (start) cmd_q[B_GO] <= 1'b0;
      if (wr && addr_i == A_CMD2) cmd2_q <= wdata_i & CMD2_MASK;
      if (wr && addr_i == A_BLK)  blk_q  <= wdata_i;
      if (eng_done) rdy_q <= 1'b1;
      else if (wr && addr_i == A_XSTS && wdata_i[B_RDY]) rdy_q <= 1'b0;
      err_q   <= (err_q & ~err_clr) | err_set;
      flush_q <= (wr && addr_i == A_FSTS) ? {wdata_i[B_RXFL], wdata_i[B_TXFL]} : 2'b00;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        A_CMD:  rdata_o = cmd_q;
        A_CMD2: rdata_o = cmd2_q;
        A_XSTS: rdata_o[B_RDY] = rdy_q;
        A_FSTS: rdata_o = {16'b0, flush_q, 5'b0, |err_q, err_q,
                           tx_full, tx_empty, rx_full, rx_empty};
        A_BLK:  rdata_o = blk_q;
        A_RXP:  rdata_o = rx_empty ? '0 : rx_head;
        default: rdata_o = '0;
      endcase
    end
  end

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_no[i] = (cmd_q[B_SEL+1:B_SEL] == 2'(i))
                    ? (cmd_q[B_SWCS] ? cmd_q[B_SWLV] : !eng_busy) : 1'b1;
  end

  // R2
  go_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start && !wr_cmd |=> !cmd_q[B_GO]);
  // R2
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> eng_busy);
  // R6
  ready_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_done |=> rdy_q);
  // R9
  tx_unr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start && tx_en && tx_empty |=> err_q[2]);
  // R5
  cs_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_no) <= 1);
endmodule

// File: tb/tb_spi_reg_master.sv
`timescale 1ns/1ps
module tb_spi_reg_master;
  localparam int CLK_DIV = 2;
  localparam logic [9:0] A_CMD = 10'h000, A_CMD2 = 10'h004, A_XSTS = 10'h010,
    A_FSTS = 10'h014, A_BLK = 10'h024, A_TXP = 10'h108, A_RXP = 10'h188;

  logic clk = 0, rst_n = 0, req = 0, we = 0;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic sck, mosi;
  logic [3:0] cs_n;
  int tests = 0, fails = 0;
  bit exp_q[$];
  bit mon_en = 0, m_cpol = 0, m_cpha = 0;
  logic [1:0] cfg_sel = 2'd1;
  bit cfg_swctl = 1, cfg_swlv = 1;

  always #4 clk = ~clk;

  spi_reg_master #(.CLK_DIV(CLK_DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sck_o(sck), .mosi_o(mosi),
    .miso_i(mosi), .cs_no(cs_n));

  task automatic check(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // scoreboard monitor: pop expected MOSI bit on each sampling edge
  always @(sck) begin
    if (mon_en && sck == (m_cpol == m_cpha)) begin
      if (exp_q.size() == 0) check(0, "R3 extra edge", 32'(sck), 32'(0));
      else begin
        bit b;
        b = exp_q.pop_front();
        check(mosi == b, "R3 mosi bit", 32'(mosi), 32'(b));
      end
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  function automatic logic [31:0] sw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] mk(input bit go, input logic [1:0] mode, input bit lsb,
                                      input bit bs, input bit rxen, input bit txen, input int len);
    return (32'(go) << 31) | (32'h1 << 30) | (32'(mode) << 28) | (32'(cfg_sel) << 26) |
           (32'(cfg_swctl) << 21) | (32'(cfg_swlv) << 20) | (32'(lsb) << 16) |
           (32'(bs) << 15) | (32'(rxen) << 12) | (32'(txen) << 11) | 32'(len);
  endfunction

  task automatic wait_ready;
    logic [31:0] v;
    bit seen = 0;
    for (int i = 0; i < 500 && !seen; i++) begin
      rd(A_XSTS, v);
      seen = v[30];
    end
    check(seen, "R6 ready set", 32'(seen), 32'd1);
    wr(A_XSTS, 32'h4000_0000);
    rd(A_XSTS, v);
    check(v == 0, "R6 ready w1c", v, 32'h0);
  endtask

  task automatic xfer(input logic [31:0] d, input int len, input logic [1:0] mode,
                      input bit lsb, input bit bs, input bit rxen, input bit txen,
                      input bit load, input bit probe, input logic [3:0] exp_cs);
    logic [31:0] c, w, v;
    realtime t0, t1;
    if (load) wr(A_TXP, d);
    c = mk(0, mode, lsb, bs, rxen, txen, len);
    wr(A_CMD, c);
    repeat (2) @(negedge clk);
    check(sck == mode[1], "R3 idle level", 32'(sck), 32'(mode[1]));
    m_cpol = mode[1]; m_cpha = mode[0];
    w = bs ? sw(d) : d;
    for (int i = 0; i <= len; i++)
      exp_q.push_back((load && txen) ? (lsb ? w[i] : w[len - i]) : 1'b0);
    mon_en = 1;
    wr(A_CMD, c | 32'h8000_0000);
    rd(A_CMD, v);
    check(v[31] == 0, "R2 go self-clears", v, c);
    check(v[30:0] == c[30:0], "R2 fields read back", v, c);
    if (probe) begin
      @(posedge sck); t0 = $realtime; #1;
      check(cs_n == exp_cs, "R5 cs during block", 32'(cs_n), 32'(exp_cs));
      @(negedge sck); t1 = $realtime;
      check(t1 - t0 == CLK_DIV * 8.0, "R3 half period", 32'(int'(t1 - t0)), 32'(CLK_DIV * 8));
    end
    wait_ready;
    mon_en = 0;
    check(exp_q.size() == 0, "R3 bit count", 32'(exp_q.size()), 32'h0);
    exp_q.delete();
  endtask

  function automatic logic [31:0] lb(input logic [31:0] d, input int len, input bit bs);
    logic [31:0] m;
    m = (len == 31) ? 32'hFFFF_FFFF : ((32'h1 << (len + 1)) - 1);
    return bs ? sw(sw(d) & m) : (d & m);
  endfunction

  initial begin
    #(8 * 150000);
    check(0, "watchdog", 32'h0, 32'h1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R1
    rd(A_FSTS, v); check(v == 32'h5, "R1 fifo status", v, 32'h5);
    rd(A_XSTS, v); check(v == 0, "R1 xfer status", v, 32'h0);
    check(cs_n == 4'hF && sck == 0, "R1 cs/sck idle", {27'b0, sck, cs_n}, 32'hF);
    // R11
    wr(A_CMD2, 32'hFFFF_FFFF); rd(A_CMD2, v); check(v == 32'h7CFF, "R11 cmd2 mask", v, 32'h7CFF);
    wr(A_BLK, 32'h5); rd(A_BLK, v); check(v == 32'h5, "R11 blk rw", v, 32'h5);
    wr(A_BLK, 32'h0);
    // R5 sw cs
    wr(A_CMD, mk(0, 2'd0, 0, 0, 1, 1, 7)); #1;
    check(cs_n == 4'hF, "R5 cs released", 32'(cs_n), 32'hF);
    cfg_swlv = 0;
    wr(A_CMD, mk(0, 2'd0, 0, 0, 1, 1, 7)); #1;
    check(cs_n == 4'b1101, "R5 cs asserted", 32'(cs_n), 32'hD);
    // R3 R7 mode 0, MSB-first
    xfer(32'hA5, 7, 2'd0, 0, 0, 1, 1, 1, 1, 4'b1101);
    rd(A_RXP, v); check(v == 32'hA5, "R7 rx 8b", v, 32'hA5);
    xfer(32'hDEADBEEF, 31, 2'd0, 0, 0, 1, 1, 1, 0, 4'h0);
    rd(A_RXP, v); check(v == 32'hDEADBEEF, "R7 rx 32b", v, 32'hDEADBEEF);
    check(cs_n == 4'b1101, "R5 cs held across blocks", 32'(cs_n), 32'hD);
    // R3 other modes
    xfer(32'h1234, 15, 2'd3, 0, 0, 1, 1, 1, 0, 4'h0);
    rd(A_RXP, v); check(v == 32'h1234, "R3 mode3 rx", v, 32'h1234);
    xfer(32'hABC, 11, 2'd1, 0, 0, 1, 1, 1, 0, 4'h0);
    rd(A_RXP, v); check(v == 32'hABC, "R3 mode1 rx", v, 32'hABC);
    xfer(32'h5A3, 9, 2'd2, 0, 0, 1, 1, 1, 0, 4'h0);
    rd(A_RXP, v); check(v == lb(32'h5A3, 9, 0), "R3 mode2 rx", v, lb(32'h5A3, 9, 0));
    // R4
    xfer(32'h01, 7, 2'd0, 1, 0, 1, 1, 1, 0, 4'h0);
    rd(A_RXP, v); check(v == 32'h01, "R4 lsb-first rx", v, 32'h01);
    xfer(32'h11223344, 31, 2'd0, 0, 1, 1, 1, 1, 0, 4'h0);
    rd(A_RXP, v); check(v == 32'h11223344, "R4 byte swap rx", v, 32'h11223344);
    // R7 rx disabled
    xfer(32'h77, 7, 2'd0, 0, 0, 0, 1, 1, 0, 4'h0);
    rd(A_FSTS, v); check(v == 32'h5, "R7 rx disabled no push", v, 32'h5);
    // R9 tx underrun
    xfer(32'h0, 7, 2'd0, 0, 0, 1, 1, 0, 0, 4'h0);
    rd(A_FSTS, v); check(v == 32'h144, "R9 tx underrun", v, 32'h144);
    rd(A_RXP, v); check(v == 32'h0, "R9 underrun shifts zeros", v, 32'h0);
    wr(A_FSTS, 32'hF0); rd(A_FSTS, v); check(v == 32'h5, "R9 w1c", v, 32'h5);
    // R8 R9 R10 tx full / overflow / flush
    for (int i = 0; i < 5; i++) wr(A_TXP, 32'(i));
    rd(A_FSTS, v); check(v == 32'h189, "R8 tx full + R9 tx ovf", v, 32'h189);
    @(negedge clk); req = 1; we = 1; addr = A_FSTS; wdata = 32'h40F0;
    @(negedge clk); we = 0; #1 v = rdata;
    @(negedge clk); req = 0;
    check(v[14] == 1, "R10 tx flush pending", v, 32'h4000);
    rd(A_FSTS, v); check(v == 32'h5, "R10 tx flushed", v, 32'h5);
    // R8 R9 rx full / overflow / underrun
    for (int i = 1; i <= 5; i++) xfer(32'(i), 7, 2'd0, 0, 0, 1, 1, 1, 0, 4'h0);
    rd(A_FSTS, v); check(v == 32'h126, "R8 rx full + R9 rx ovf", v, 32'h126);
    for (int i = 1; i <= 4; i++) begin
      rd(A_RXP, v); check(v == 32'(i), "R7 rx order", v, 32'(i));
    end
    rd(A_RXP, v); check(v == 0, "R9 rx underrun data", v, 32'h0);
    rd(A_FSTS, v); check(v == 32'h135, "R9 rx underrun flag", v, 32'h135);
    wr(A_FSTS, 32'hF0);
    // R10 rx flush
    xfer(32'h99, 7, 2'd0, 0, 0, 1, 1, 1, 0, 4'h0);
    rd(A_FSTS, v); check(v == 32'h4, "R8 rx nonempty", v, 32'h4);
    wr(A_FSTS, 32'h8000); rd(A_FSTS, v); check(v == 32'h5, "R10 rx flushed", v, 32'h5);
    // R5 hardware cs and release
    cfg_swctl = 0; cfg_swlv = 1; cfg_sel = 2'd2;
    wr(A_CMD, mk(0, 2'd0, 0, 0, 1, 1, 7)); #1;
    check(cs_n == 4'hF, "R5 hw cs idle", 32'(cs_n), 32'hF);
    xfer(32'h3C, 7, 2'd0, 0, 0, 1, 1, 1, 1, 4'b1011);
    #1 check(cs_n == 4'hF, "R5 hw cs released", 32'(cs_n), 32'hF);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule